// File: doc/BRIEF.md
# Counted SPI Burst Shift Engine

This block is the shifting core of an SPI master. A start request launches one burst whose total length in bytes is given by a burst count. A separate transmit count says how many of those bytes are taken from the transmit byte stream. Any bytes left in the burst after the transmit count is used up are sent as zero bytes. Each byte received during the burst goes out on a receive byte stream. Transmit-only transfers can set a discard option so that nothing is captured. The serial clock moves one half period on each pulse of an external strobe, `sck_tick`, so the block does not divide clocks itself.

Both byte streams use valid/ready handshakes. A transmit byte is consumed in a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is raised only at a byte boundary, only while transmit bytes are still owed, and only when the receive holder has room. A received byte stays on `rx_data`, with `rx_valid` held high, until `rx_ready` accepts it. The engine does not start the next byte while that byte is still held. Back-pressure on either stream therefore stalls the burst at a byte boundary, with the serial clock parked at its idle level.

The engine supports both clock polarities and both clock phases, MSB-first or LSB-first order, and one, two or four data lanes. It drives four chip-select lines, either automatically or as a manual level. It pulses `done` at the end of the burst.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset `busy`, `done`, `rx_valid` and `tx_ready` are low, `sclk` equals `cpol`, and with `cs_manual` low every chip-select line sits at its inactive level (the inverse of `cs_act_high`).
- R2: A one-cycle `go` while idle starts a burst of `burst_len` bytes. A `go` while busy is ignored. A `go` with `burst_len` zero gives `done` on the next cycle without any serial clock edge.
- R3: Bytes 0 to `tx_len`-1 of the burst are taken in order from the transmit stream, and every later byte is sent as 8'h00. When `tx_len` is at least `burst_len`, exactly `burst_len` bytes are taken.
- R4: `sclk` idles at `cpol`. With `cpha` 0 each bit is valid before the leading (first) edge of its clock period and is sampled on that edge. With `cpha` 1 bits change on the leading edge and are sampled on the trailing edge.
- R5: With `lsb_first` low, bit 7 of each byte goes first. With `lsb_first` high, bit 0 goes first. Within one beat, the lower-numbered lane carries the less significant bit.
- R6: `lane_mode` 2'b00 (and 2'b11) selects a single lane: out on `sd_out[0]`, in from `sd_in[1]`, 8 clock periods per byte. 2'b01 uses lanes 1:0 for 4 periods per byte. 2'b10 uses lanes 3:0 for 2 periods per byte. Unused `sd_out` lanes are 0.
- R7: Each received byte is presented on `rx_data` with `rx_valid` and held unchanged until `rx_ready`. The next byte does not start while a byte is held.
- R8: With `rx_discard` high, `rx_valid` never rises during the burst, and a held receive byte does not stall the burst.
- R9: `done` is a one-cycle pulse in the cycle after the final clock edge of the last byte. `busy` is low from that same cycle.
- R10: When `cs_manual` is low, line `cs_sel` is driven to the active level while busy. When `cs_manual` is high, line `cs_sel` is driven to `cs_level`. All other lines stay inactive.
- R11: While a transmit byte is owed and `tx_valid` is low, the burst waits with `sclk` at idle and no clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_tick | input | 1 | Half-period strobe for the serial clock |
| go | input | 1 | Start-of-burst request (one cycle) |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase select |
| lsb_first | input | 1 | Send and receive bit 0 first |
| rx_discard | input | 1 | Drop received bytes |
| lane_mode | input | 2 | 00 single, 01 dual, 10 quad, 11 single |
| burst_len | input | CNT_W (24) | Total bytes in the burst |
| tx_len | input | CNT_W (24) | Bytes taken from the transmit stream |
| cs_sel | input | clog2(CS_N) (2) | Chip-select line index |
| cs_manual | input | 1 | Drive the selected line to `cs_level` |
| cs_level | input | 1 | Level for the selected line in manual mode |
| cs_act_high | input | 1 | Chip-select active level is high |
| tx_valid | input | 1 | Transmit byte available |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Engine takes the transmit byte |
| rx_valid | output | 1 | Received byte held |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Consumer accepts the received byte |
| sclk | output | 1 | Serial clock |
| sd_out | output | 4 | Outgoing data lanes |
| sd_in | input | 4 | Incoming data lanes |
| cs_o | output | CS_N (4) | Chip-select lines |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Burst finished (one cycle) |

## Verification
The assertions assume that the mode inputs, the two counts and the chip-select setup stay constant from `go` until `done`, and that `go` is a single-cycle pulse. The bench changes these inputs only while the engine is idle. It holds them through each burst and pulses `go` for exactly one clock. The one `go` it raises mid-burst tests that a second request is ignored. The bench strobes `sck_tick` every second clock. It loops `sd_out` back to `sd_in` according to the lane mode, and it rebuilds every byte on the sampling edges from the mode rules alone.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic       lsb;
    logic       discard;
    logic [1:0] lanes;
  } burst_cfg_t;

  // clock periods needed to move one byte for a lane selection
  function automatic logic [3:0] beats_of(input logic [1:0] lanes);
    case (lanes)
      2'b01:   beats_of = 4'd4;
      2'b10:   beats_of = 4'd2;
      default: beats_of = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/spi_lane_shifter.sv
module spi_lane_shifter
  import spi_burst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic [1:0] lanes,
  input  logic       lsb,
  input  logic       shift_en,
  input  logic       sample_en,
  input  logic [3:0] sd_in,
  output logic [3:0] sd_out,
  output logic [7:0] rx_next
);

  logic [7:0] tx_sh, rx_sh, in8;
  logic [3:0] in_bits;
  int         nb;

  always_comb begin
    case (lanes)
      2'b01: begin
        nb      = 2;
        sd_out  = {2'b00, lsb ? tx_sh[1:0] : tx_sh[7:6]};
        in_bits = {2'b00, sd_in[1:0]};
      end
      2'b10: begin
        nb      = 4;
        sd_out  = lsb ? tx_sh[3:0] : tx_sh[7:4];
        in_bits = sd_in;
      end
      default: begin
        nb      = 1;
        sd_out  = {3'b000, lsb ? tx_sh[0] : tx_sh[7]};
        in_bits = {3'b000, sd_in[1]};
      end
    endcase
    in8 = {4'b0000, in_bits};
    if (!sample_en) rx_next = rx_sh;
    else if (lsb)   rx_next = (rx_sh >> nb) | (in8 << (8 - nb));
    else            rx_next = (rx_sh << nb) | in8;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= 8'h00;
      rx_sh <= 8'h00;
    end else if (load) begin
      tx_sh <= load_byte;
      rx_sh <= 8'h00;
    end else begin
      if (shift_en) tx_sh <= lsb ? (tx_sh >> nb) : (tx_sh << nb);
      rx_sh <= rx_next;
    end
  end

  // R4
  edge_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_en && sample_en));

endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter  int CS_N  = 4,
  localparam int SEL_W = $clog2(CS_N)
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             manual,
  input  logic             level,
  input  logic             act_high,
  input  logic             busy,
  output logic [CS_N-1:0]  cs_o
);

  logic sel_level;
  assign sel_level = manual ? level : (busy ? act_high : ~act_high);

  for (genvar i = 0; i < CS_N; i++) begin : g_line
    assign cs_o[i] = (sel == SEL_W'(i)) ? sel_level : ~act_high;
  end

endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             go,
  input  burst_cfg_t       cfg_in,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [CNT_W-1:0] tx_len,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  input  logic             rx_ready,
  input  logic [7:0]       rx_next,
  output logic             load,
  output logic [7:0]       load_byte,
  output logic             shift_en,
  output logic             sample_en,
  output logic             sclk_act,
  output burst_cfg_t       cfg,
  output logic             busy,
  output logic             done
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SHIFT} seq_state_e;

  seq_state_e       st;
  logic [CNT_W-1:0] burst_q, txlen_q, idx;
  logic [3:0]       h, last_h;
  logic [4:0]       two_b;
  logic             need_tx, rx_room, lead, trail, byte_end, last_byte;

  always_comb begin
    need_tx   = idx < txlen_q;
    rx_room   = cfg.discard || !rx_valid;
    tx_ready  = (st == S_WAIT) && need_tx && rx_room;
    load      = (st == S_WAIT) && rx_room && (!need_tx || tx_valid);
    load_byte = need_tx ? tx_data : 8'h00;
    two_b     = {beats_of(cfg.lanes), 1'b0};
    last_h    = 4'(two_b - 5'd1);
    lead      = tick && (st == S_SHIFT) && !h[0];
    trail     = tick && (st == S_SHIFT) && h[0];
    shift_en  = cfg.cpha ? (lead && (h != 4'd0)) : trail;
    sample_en = cfg.cpha ? trail : lead;
    byte_end  = trail && (h == last_h);
    last_byte = idx == (burst_q - CNT_W'(1));
    sclk_act  = (st == S_SHIFT) && h[0];
    busy      = st != S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cfg      <= '0;
      burst_q  <= '0;
      txlen_q  <= '0;
      idx      <= '0;
      h        <= '0;
      rx_valid <= 1'b0;
      rx_data  <= 8'h00;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          cfg     <= cfg_in;
          burst_q <= burst_len;
          txlen_q <= tx_len;
          idx     <= '0;
          if (burst_len == '0) done <= 1'b1;
          else                 st   <= S_WAIT;
        end
        S_WAIT: if (load) begin
          h  <= '0;
          st <= S_SHIFT;
        end
        default: if (tick) begin
          h <= h + 4'd1;
          if (byte_end) begin
            h   <= '0;
            idx <= idx + CNT_W'(1);
            if (!cfg.discard) begin
              rx_valid <= 1'b1;
              rx_data  <= rx_next;
            end
            if (last_byte) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              st <= S_WAIT;
            end
          end
        end
      endcase
    end
  end

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  byte_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx < burst_q));

  // R8
  discard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg.discard && !rx_valid) |=> !rx_valid);

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter  int CNT_W = 24,
  parameter  int CS_N  = 4,
  localparam int SEL_W = $clog2(CS_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_tick,
  input  logic             go,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic             rx_discard,
  input  logic [1:0]       lane_mode,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [CNT_W-1:0] tx_len,
  input  logic [SEL_W-1:0] cs_sel,
  input  logic             cs_manual,
  input  logic             cs_level,
  input  logic             cs_act_high,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  input  logic             rx_ready,
  output logic             sclk,
  output logic [3:0]       sd_out,
  input  logic [3:0]       sd_in,
  output logic [CS_N-1:0]  cs_o,
  output logic             busy,
  output logic             done
);

  burst_cfg_t cfg_in, cfg;
  logic       load, shift_en, sample_en, sclk_act;
  logic [7:0] load_byte, rx_next;

  assign cfg_in = '{cpol: cpol, cpha: cpha, lsb: lsb_first,
                    discard: rx_discard, lanes: lane_mode};

  spi_burst_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(sck_tick), .go(go), .cfg_in(cfg_in),
    .burst_len(burst_len), .tx_len(tx_len),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_next(rx_next), .load(load), .load_byte(load_byte),
    .shift_en(shift_en), .sample_en(sample_en), .sclk_act(sclk_act),
    .cfg(cfg), .busy(busy), .done(done)
  );

  spi_lane_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(load_byte),
    .lanes(cfg.lanes), .lsb(cfg.lsb), .shift_en(shift_en),
    .sample_en(sample_en), .sd_in(sd_in), .sd_out(sd_out), .rx_next(rx_next)
  );

  spi_cs_drive #(.CS_N(CS_N)) u_cs (
    .sel(cs_sel), .manual(cs_manual), .level(cs_level),
    .act_high(cs_act_high), .busy(busy), .cs_o(cs_o)
  );

  assign sclk = busy ? (cfg.cpol ^ sclk_act) : cpol;

endmodule

// File: tb/spi_burst_engine_bench.sv
module spi_burst_engine_bench;

  typedef struct packed {
    logic [7:0] burst;
    logic [7:0] txlen;
    logic [1:0] lanes;
    logic       cpol;
    logic       cpha;
    logic       lsb;
    logic       disc;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'd3, 8'd3, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd4, 8'd2, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0},
    '{8'd2, 8'd5, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'd3, 8'd3, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd3, 8'd1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0},
    '{8'd2, 8'd2, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1},
    '{8'd2, 8'd2, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'd2, 8'd2, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, go = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, lsb = 1'b0, disc = 1'b0;
  logic [1:0]  lanes = 2'b00;
  logic [23:0] burst_len = '0, tx_len = '0;
  logic [1:0]  cs_sel = 2'd0;
  logic cs_manual = 1'b0, cs_level = 1'b0, cs_act_high = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_ready, rx_valid, sclk, busy, done;
  logic [7:0] rx_data;
  logic [3:0] sd_out, sd_in, cs_o;

  assign sd_in = (lanes == 2'b01 || lanes == 2'b10) ? sd_out : {2'b00, sd_out[0], 1'b0};

  spi_burst_engine u_spi_burst_engine (
    .clk(clk), .rst_n(rst_n), .sck_tick(tick), .go(go), .cpol(cpol),
    .cpha(cpha), .lsb_first(lsb), .rx_discard(disc), .lane_mode(lanes),
    .burst_len(burst_len), .tx_len(tx_len), .cs_sel(cs_sel),
    .cs_manual(cs_manual), .cs_level(cs_level), .cs_act_high(cs_act_high),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .sclk(sclk), .sd_out(sd_out), .sd_in(sd_in), .cs_o(cs_o),
    .busy(busy), .done(done)
  );

  always #10 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] txb(input int v, input int i);
    return 8'((8'hC3 ^ (v * 37)) ^ (i * 90));
  endfunction

  function automatic int beats(input logic [1:0] l);
    return (l == 2'b01) ? 4 : (l == 2'b10) ? 2 : 8;
  endfunction

  // independent slave-side monitor: rebuilds bytes on the sampling edges
  logic [7:0] mon_bytes [16];
  int mon_n = 0, mon_bits = 0, lead_cnt = 0;
  logic [7:0] mon_sh = 8'h00;
  logic prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (rst_n && sclk != prev_sclk) begin
      automatic bit is_lead = (sclk != cpol);
      automatic int n = beats(lanes) == 8 ? 1 : (beats(lanes) == 4 ? 2 : 4);
      automatic logic [7:0] b8 = (n == 1) ? {7'd0, sd_out[0]} :
                                 (n == 2) ? {6'd0, sd_out[1:0]} : {4'd0, sd_out};
      if (is_lead) lead_cnt++;
      if (is_lead == !cpha) begin
        mon_sh = lsb ? ((mon_sh >> n) | (b8 << (8 - n))) : ((mon_sh << n) | b8);
        mon_bits += n;
        if (mon_bits == 8) begin
          if (mon_n < 16) mon_bytes[mon_n] = mon_sh;
          mon_n++;
          mon_bits = 0;
          mon_sh = 8'h00;
        end
      end
    end
    prev_sclk = sclk;
  end

  // mode: 0 plain, 1 hold tx stream, 2 hold rx stream, 3 second go mid-burst
  task automatic run_xfer(input int v, input vec_t p, input int mode);
    logic [7:0] rx_got [16];
    int rx_n = 0, popped = 0, done_n = 0, t = 0, cs_bad = 0, exp_pop;
    bit fire;
    @(negedge clk);
    lanes = p.lanes; cpol = p.cpol; cpha = p.cpha; lsb = p.lsb; disc = p.disc;
    burst_len = 24'(p.burst); tx_len = 24'(p.txlen);
    @(negedge clk);
    mon_n = 0; mon_bits = 0; mon_sh = 8'h00; lead_cnt = 0;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    while (done_n == 0 && t < 5000) begin
      tx_valid = (popped < p.txlen) && !(mode == 1 && t < 40);
      tx_data  = txb(v, popped);
      rx_ready = !(mode == 2 && t < 150);
      go = (mode == 3 && t == 20);
      #1;
      if (mode == 1 && t == 30)
        chk(busy && lead_cnt == 0 && sclk == cpol, "R11 stall on empty tx", lead_cnt, 0);
      if (mode == 2 && t == 140)
        chk(rx_valid && lead_cnt == beats(p.lanes), "R7 stall on held rx", lead_cnt, beats(p.lanes));
      fire = tx_valid && tx_ready;
      if (rx_valid && rx_ready) begin
        if (rx_n < 16) rx_got[rx_n] = rx_data;
        rx_n++;
      end
      if (busy && cs_o != (cs_manual ? cs_o : (4'b1111 ^ (4'b0001 << cs_sel) ^ {4{cs_act_high}})))
        cs_bad++;
      if (done) done_n++;
      @(posedge clk);
      if (fire) popped++;
      @(negedge clk);
      t++;
    end
    go = 1'b0; tx_valid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      rx_ready = 1'b1;
      #1;
      if (rx_valid) begin
        if (rx_n < 16) rx_got[rx_n] = rx_data;
        rx_n++;
      end
      if (done) done_n++;
      @(negedge clk);
    end
    chk(done_n == 1 && !busy, "R9 single done then idle", done_n, 1);
    chk(sclk == cpol, "R4 idle clock level", sclk, cpol);
    chk(mon_n == p.burst, "R2 bytes in burst", mon_n, p.burst);
    chk(lead_cnt == p.burst * beats(p.lanes), "R6 clock periods", lead_cnt, p.burst * beats(p.lanes));
    exp_pop = (p.txlen < p.burst) ? p.txlen : p.burst;
    chk(popped == exp_pop, "R3 bytes taken from tx stream", popped, exp_pop);
    for (int i = 0; i < p.burst && i < 16; i++) begin
      automatic logic [7:0] e = (i < p.txlen) ? txb(v, i) : 8'h00;
      chk(mon_bytes[i] === e, "R3 R4 R5 R6 line byte", mon_bytes[i], e);
    end
    if (p.disc) chk(rx_n == 0, "R8 nothing captured", rx_n, 0);
    else begin
      chk(rx_n == p.burst, "R7 rx byte count", rx_n, p.burst);
      for (int i = 0; i < p.burst && i < 16; i++) begin
        automatic logic [7:0] e = (i < p.txlen) ? txb(v, i) : 8'h00;
        chk(rx_got[i] === e, "R7 rx byte value", rx_got[i], e);
      end
    end
    chk(cs_bad == 0, "R10 chip select during burst", cs_bad, 0);
  endtask

  bit finished = 1'b0;

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !rx_valid && !tx_ready, "R1 reset outputs", {busy, done, rx_valid, tx_ready}, 0);
    chk(sclk == 1'b0 && cs_o == 4'b1111, "R1 idle clock and chip selects", {sclk, cs_o}, 5'b01111);

    for (int v = 0; v < NV; v++) run_xfer(v, VECS[v], 0);

    // R2 zero-length burst
    burst_len = '0; tx_len = '0; lead_cnt = 0;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk(done && !busy && lead_cnt == 0, "R2 zero burst done", {done, busy}, 2'b10);
    @(negedge clk);
    chk(!done, "R9 done lasts one cycle", done, 0);

    // R2 second go while busy is ignored
    run_xfer(10, '{8'd2, 8'd2, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0}, 3);
    // R11 tx back-pressure
    run_xfer(11, '{8'd2, 8'd2, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0}, 1);
    // R7 rx back-pressure, with R10 automatic active-high select on line 2
    cs_sel = 2'd2; cs_act_high = 1'b1;
    run_xfer(12, '{8'd2, 8'd1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0}, 2);
    chk(cs_o == 4'b0000, "R10 inactive after burst", cs_o, 0);

    // R10 manual chip select
    cs_sel = 2'd1; cs_act_high = 1'b0; cs_manual = 1'b1; cs_level = 1'b0;
    @(negedge clk);
    chk(cs_o == 4'b1101, "R10 manual level", cs_o, 4'b1101);
    cs_level = 1'b1;
    @(negedge clk);
    chk(cs_o == 4'b1111, "R10 manual level high", cs_o, 4'b1111);
    cs_manual = 1'b0;

    finish_up();
  end

endmodule